// File: doc/BRIEF.md
# Redundant-Core Retirement Checker

This block sits between two cores that run the same program in lockstep. Each cycle, each core presents the record of the instruction it retires: the instruction class, the branch outcome and next program counter, the memory address and access size, the store data, the system-call argument registers and an optional register-file write. Control flow, stores, access alignment and system-call inputs are checked in the cycle the record arrives.

Register writes are not compared one by one. Each core's writes are folded into a short running signature, and the two signatures are compared once per programmable number of retired instructions. After each comparison both signatures start again from a fixed seed.

Any violation raises a rollback request with a 3-bit cause code. The request stays high until the recovery logic acknowledges it. The recovery logic then restores the last checkpoint.

Top module: `dmr_retire_checker`

## Requirements
- R1: While reset is active and after it is released, `rollback_o` is 0 and `cause_o` is 0 (no cause) until a violation is seen.
- R2: A cycle in which exactly one of `a_valid_i`, `b_valid_i` is high is a control violation (cause 1).
- R3: With both records valid, a different class, a different next program counter, or, for the branch class (code 1), a different taken bit is a control violation (cause 1). The taken bit is ignored for every other class.
- R4: With both records of the store class (code 3), a different address is a store-address violation (cause 3).
- R5: With both records of the store class, the store data is compared only over the low 2^size bytes, where the size code is 0, 1, 2 or 3 for 1, 2, 4 or 8 bytes. A difference in those bytes is a store-value violation (cause 2), and a difference in the other bytes has no effect.
- R6: A valid load (code 2) or store (code 3) whose address has any of its low `size` bits set is an alignment violation (cause 4), even when both cores agree.
- R7: With both records of the system-call class (code 4), any difference in the argument values is a system-call violation (cause 5).
- R8: Each valid record with its write enable high folds into its core's signature: sig = rotl(sig,1) XOR value XOR (index * 0x9E37), truncated to the signature width. The signatures are compared at the retirement that completes a period, including that retirement's own write. A difference is a signature violation (cause 6), and no signature violation is raised at any other retirement.
- R9: A period counts cycles in which both records are valid, and its length comes from `cfg_period_i`; a value of 0 acts as 1. After each comparison, whether it matched or not, both signatures return to the seed.
- R10: Once raised, `rollback_o` and `cause_o` hold until `ack_i` is high. An acknowledge with no violation in the same cycle clears both; a violation in the acknowledge cycle loads its own cause.
- R11: When several violations occur together, the reported cause follows this priority: control, store address, store value, alignment, system call, signature.
- R12: The rollback request and its cause appear at the first clock edge after the offending records are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_i | input | 1 | Acknowledge that clears the rollback request |
| cfg_period_i | input | PER_W | Signature comparison period in retirements |
| a_valid_i | input | 1 | Core A retires a record this cycle |
| a_class_i | input | 3 | Core A class: 0 ALU, 1 branch, 2 load, 3 store, 4 syscall |
| a_taken_i | input | 1 | Core A branch outcome |
| a_npc_i | input | XLEN | Core A next program counter |
| a_addr_i | input | XLEN | Core A memory address |
| a_size_i | input | 2 | Core A access size code (log2 bytes) |
| a_sdata_i | input | XLEN | Core A store data |
| a_sys_i | input | NARGS*XLEN | Core A system-call argument values |
| a_we_i | input | 1 | Core A register write enable |
| a_idx_i | input | IDX_W | Core A destination register index |
| a_wval_i | input | XLEN | Core A register write value |
| b_valid_i | input | 1 | Core B retires a record this cycle |
| b_class_i | input | 3 | Core B class |
| b_taken_i | input | 1 | Core B branch outcome |
| b_npc_i | input | XLEN | Core B next program counter |
| b_addr_i | input | XLEN | Core B memory address |
| b_size_i | input | 2 | Core B access size code |
| b_sdata_i | input | XLEN | Core B store data |
| b_sys_i | input | NARGS*XLEN | Core B system-call argument values |
| b_we_i | input | 1 | Core B register write enable |
| b_idx_i | input | IDX_W | Core B destination register index |
| b_wval_i | input | XLEN | Core B register write value |
| rollback_o | output | 1 | Sticky rollback request |
| cause_o | output | 3 | Violation cause: 0 none, 1 control, 2 store value, 3 store address, 4 alignment, 5 syscall, 6 signature |

## Verification
The bench sweeps every size code against every low address pattern for both loads and stores. A design that decodes the size mask wrongly would flag aligned accesses or pass misaligned ones. It also flips each store-data byte under each size, which catches a design that compares the full word or too few bytes. Register-write differences are swept over every index pair and placed at different points in a period. A design that compares early, forgets to reseed after a mismatch, or counts one-sided records would report in the wrong cycle or keep reporting in later periods. Combined violations check the cause priority, and acknowledge cycles that carry a fresh violation check that the new cause is loaded and not dropped.

// File: rtl/dmrc_pkg.sv
package dmrc_pkg;

  typedef enum logic [2:0] {
    CLS_ALU = 3'd0,
    CLS_BR  = 3'd1,
    CLS_LD  = 3'd2,
    CLS_ST  = 3'd3,
    CLS_SYS = 3'd4
  } rclass_e;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_CTRL  = 3'd1,
    CAUSE_SVAL  = 3'd2,
    CAUSE_SADDR = 3'd3,
    CAUSE_ALIGN = 3'd4,
    CAUSE_SYS   = 3'd5,
    CAUSE_SIG   = 3'd6
  } cause_e;

  localparam logic [15:0] MIX_K = 16'h9E37;

endpackage

// File: rtl/dmrc_field_cmp.sv
module dmrc_field_cmp
  import dmrc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NARGS = 2
) (
  input  logic                  a_valid,
  input  logic [2:0]            a_class,
  input  logic                  a_taken,
  input  logic [XLEN-1:0]       a_npc,
  input  logic [XLEN-1:0]       a_addr,
  input  logic [1:0]            a_size,
  input  logic [XLEN-1:0]       a_sdata,
  input  logic [NARGS*XLEN-1:0] a_sys,
  input  logic                  b_valid,
  input  logic [2:0]            b_class,
  input  logic                  b_taken,
  input  logic [XLEN-1:0]       b_npc,
  input  logic [XLEN-1:0]       b_addr,
  input  logic [1:0]            b_size,
  input  logic [XLEN-1:0]       b_sdata,
  input  logic [NARGS*XLEN-1:0] b_sys,
  output logic                  err_ctrl,
  output logic                  err_saddr,
  output logic                  err_sval,
  output logic                  err_align,
  output logic                  err_sys
);

  localparam int NBYTES = XLEN / 8;

  logic            both;
  logic            both_st;
  logic [XLEN-1:0] dmask;
  logic [1:0]      mis;
  logic [1:0]      vld_v;
  logic [2:0]      cls_v  [2];
  logic [2:0]      alo_v  [2];
  logic [1:0]      size_v [2];

  assign vld_v     = {b_valid, a_valid};
  assign cls_v[0]  = a_class;
  assign cls_v[1]  = b_class;
  assign alo_v[0]  = a_addr[2:0];
  assign alo_v[1]  = b_addr[2:0];
  assign size_v[0] = a_size;
  assign size_v[1] = b_size;

  // per-core alignment test
  for (genvar g = 0; g < 2; g++) begin : g_align
    logic [3:0] span;
    logic [2:0] amask;
    logic       is_mem;
    always_comb begin
      span   = 4'b0001 << size_v[g];
      amask  = 3'(span - 4'd1);
      is_mem = (cls_v[g] == CLS_LD) || (cls_v[g] == CLS_ST);
      mis[g] = vld_v[g] && is_mem && ((alo_v[g] & amask) != 3'd0);
    end
  end

  // bytes of store data that the access actually writes
  always_comb begin
    for (int k = 0; k < NBYTES; k++) begin
      dmask[k*8 +: 8] = (k < (1 << a_size)) ? 8'hFF : 8'h00;
    end
  end

  always_comb begin
    both      = a_valid && b_valid;
    both_st   = both && (a_class == CLS_ST) && (b_class == CLS_ST);
    err_ctrl  = (a_valid != b_valid) ||
                (both && ((a_class != b_class) || (a_npc != b_npc) ||
                          ((a_class == CLS_BR) && (a_taken != b_taken))));
    err_saddr = both_st && (a_addr != b_addr);
    err_sval  = both_st && (((a_sdata ^ b_sdata) & dmask) != '0);
    err_align = |mis;
    err_sys   = both && (a_class == CLS_SYS) && (b_class == CLS_SYS) &&
                (a_sys != b_sys);
  end

endmodule

// File: rtl/dmrc_sig_fold.sv
module dmrc_sig_fold
  import dmrc_pkg::*;
#(
  parameter int               SIG_W = 16,
  parameter int               IDX_W = 5,
  parameter int               XLEN  = 32,
  parameter logic [SIG_W-1:0] SEED  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  val,
  input  logic             restart,
  output logic [SIG_W-1:0] sig_nx
);

  localparam int PW = IDX_W + 16;

  logic [PW-1:0]    prod;
  logic [SIG_W-1:0] sig_q;
  logic [SIG_W-1:0] folded;
  logic [SIG_W-1:0] sig_d;
  logic             sig_en;

  always_comb begin
    prod   = PW'(idx) * PW'(MIX_K);
    folded = {sig_q[SIG_W-2:0], sig_q[SIG_W-1]} ^ SIG_W'(val) ^ SIG_W'(prod);
    sig_nx = we ? folded : sig_q;
    sig_d  = restart ? SEED : sig_nx;
    sig_en = restart || we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= SEED;
    end else if (sig_en) begin
      sig_q <= sig_d;
    end
  end

endmodule

// File: rtl/dmrc_fault_latch.sv
module dmrc_fault_latch
  import dmrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack,
  input  logic       err_ctrl,
  input  logic       err_saddr,
  input  logic       err_sval,
  input  logic       err_align,
  input  logic       err_sys,
  input  logic       err_sig,
  output logic       rollback,
  output logic [2:0] cause
);

  cause_e enc;
  logic   any_err;
  logic   roll_d;
  cause_e cause_q;
  cause_e cause_d;
  logic   lat_en;

  always_comb begin
    if      (err_ctrl)  enc = CAUSE_CTRL;
    else if (err_saddr) enc = CAUSE_SADDR;
    else if (err_sval)  enc = CAUSE_SVAL;
    else if (err_align) enc = CAUSE_ALIGN;
    else if (err_sys)   enc = CAUSE_SYS;
    else if (err_sig)   enc = CAUSE_SIG;
    else                enc = CAUSE_NONE;
    any_err = (enc != CAUSE_NONE);
    lat_en  = ack || (any_err && !rollback);
    roll_d  = any_err;
    cause_d = enc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rollback <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else if (lat_en) begin
      rollback <= roll_d;
      cause_q  <= cause_d;
    end
  end

  assign cause = cause_q;

endmodule

// File: rtl/dmr_retire_checker.sv
module dmr_retire_checker
  import dmrc_pkg::*;
#(
  parameter int               XLEN     = 32,
  parameter int               NARGS    = 2,
  parameter int               IDX_W    = 5,
  parameter int               SIG_W    = 16,
  parameter int               PER_W    = 8,
  parameter logic [SIG_W-1:0] SIG_SEED = SIG_W'(16'hACE1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ack_i,
  input  logic [PER_W-1:0]      cfg_period_i,
  input  logic                  a_valid_i,
  input  logic [2:0]            a_class_i,
  input  logic                  a_taken_i,
  input  logic [XLEN-1:0]       a_npc_i,
  input  logic [XLEN-1:0]       a_addr_i,
  input  logic [1:0]            a_size_i,
  input  logic [XLEN-1:0]       a_sdata_i,
  input  logic [NARGS*XLEN-1:0] a_sys_i,
  input  logic                  a_we_i,
  input  logic [IDX_W-1:0]      a_idx_i,
  input  logic [XLEN-1:0]       a_wval_i,
  input  logic                  b_valid_i,
  input  logic [2:0]            b_class_i,
  input  logic                  b_taken_i,
  input  logic [XLEN-1:0]       b_npc_i,
  input  logic [XLEN-1:0]       b_addr_i,
  input  logic [1:0]            b_size_i,
  input  logic [XLEN-1:0]       b_sdata_i,
  input  logic [NARGS*XLEN-1:0] b_sys_i,
  input  logic                  b_we_i,
  input  logic [IDX_W-1:0]      b_idx_i,
  input  logic [XLEN-1:0]       b_wval_i,
  output logic                  rollback_o,
  output logic [2:0]            cause_o
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  // immediate field checks
  logic err_ctrl, err_saddr, err_sval, err_align, err_sys, err_sig;

  dmrc_field_cmp #(.XLEN(XLEN), .NARGS(NARGS)) u_cmp (
    .a_valid (a_valid_i), .a_class (a_class_i), .a_taken (a_taken_i),
    .a_npc   (a_npc_i),   .a_addr  (a_addr_i),  .a_size  (a_size_i),
    .a_sdata (a_sdata_i), .a_sys   (a_sys_i),
    .b_valid (b_valid_i), .b_class (b_class_i), .b_taken (b_taken_i),
    .b_npc   (b_npc_i),   .b_addr  (b_addr_i),  .b_size  (b_size_i),
    .b_sdata (b_sdata_i), .b_sys   (b_sys_i),
    .err_ctrl (err_ctrl), .err_saddr (err_saddr), .err_sval (err_sval),
    .err_align(err_align), .err_sys  (err_sys)
  );

  // period counter over joint retirements
  logic             retire;
  logic             last;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    retire = a_valid_i && b_valid_i;
    last   = retire && ((cfg_period_i <= PER_W'(1)) ||
                        (cnt_q >= (cfg_period_i - PER_W'(1))));
    cnt_d  = last ? '0 : (cnt_q + PER_W'(1));
    cnt_en = retire;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // one signature per core
  logic             we_v  [2];
  logic [IDX_W-1:0] idx_v [2];
  logic [XLEN-1:0]  val_v [2];
  logic [SIG_W-1:0] sig_v [2];

  assign we_v[0]  = a_valid_i && a_we_i;
  assign we_v[1]  = b_valid_i && b_we_i;
  assign idx_v[0] = a_idx_i;
  assign idx_v[1] = b_idx_i;
  assign val_v[0] = a_wval_i;
  assign val_v[1] = b_wval_i;

  for (genvar g = 0; g < 2; g++) begin : g_sig
    dmrc_sig_fold #(
      .SIG_W(SIG_W), .IDX_W(IDX_W), .XLEN(XLEN), .SEED(SIG_SEED)
    ) u_sig (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .we      (we_v[g]),
      .idx     (idx_v[g]),
      .val     (val_v[g]),
      .restart (last),
      .sig_nx  (sig_v[g])
    );
  end

  assign err_sig = last && (sig_v[0] != sig_v[1]);

  dmrc_fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ack       (ack_i),
    .err_ctrl  (err_ctrl),
    .err_saddr (err_saddr),
    .err_sval  (err_sval),
    .err_align (err_align),
    .err_sys   (err_sys),
    .err_sig   (err_sig),
    .rollback  (rollback_o),
    .cause     (cause_o)
  );

endmodule

// File: rtl/dmrc_chk.sv
module dmrc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n_s,
  input logic            ack_i,
  input logic            a_valid_i,
  input logic            b_valid_i,
  input logic [2:0]      a_class_i,
  input logic [2:0]      b_class_i,
  input logic [XLEN-1:0] a_npc_i,
  input logic [XLEN-1:0] b_npc_i,
  input logic [XLEN-1:0] a_addr_i,
  input logic [1:0]      a_size_i,
  input logic            rollback_o,
  input logic [2:0]      cause_o
);

  // R2
  ctrl_onesided_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (a_valid_i != b_valid_i) && !rollback_o |=> rollback_o && (cause_o == 3'd1));

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rollback_o && !ack_i |=> rollback_o && $stable(cause_o));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rollback_o && ack_i && !a_valid_i && !b_valid_i |=> !rollback_o);

  // R1
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rollback_o |-> (cause_o == 3'd0));

  // R11
  raised_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rollback_o |-> (cause_o != 3'd0) && (cause_o <= 3'd6));

  // R6
  load_align_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    a_valid_i && b_valid_i && (a_class_i == 3'd2) && (b_class_i == 3'd2) &&
    (a_npc_i == b_npc_i) && a_addr_i[0] && (a_size_i != 2'd0) && !rollback_o
    |=> rollback_o && (cause_o == 3'd4));

endmodule

bind dmr_retire_checker dmrc_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .ack_i      (ack_i),
  .a_valid_i  (a_valid_i),
  .b_valid_i  (b_valid_i),
  .a_class_i  (a_class_i),
  .b_class_i  (b_class_i),
  .a_npc_i    (a_npc_i),
  .b_npc_i    (b_npc_i),
  .a_addr_i   (a_addr_i),
  .a_size_i   (a_size_i),
  .rollback_o (rollback_o),
  .cause_o    (cause_o)
);

// File: tb/dmr_retire_checker_tb_top.sv
module dmr_retire_checker_tb_top;

  localparam logic [15:0] SEED = 16'hACE1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ack_i;
  logic [7:0]  cfg_period_i;
  logic        a_valid_i, b_valid_i;
  logic [2:0]  a_class_i, b_class_i;
  logic        a_taken_i, b_taken_i;
  logic [31:0] a_npc_i, b_npc_i, a_addr_i, b_addr_i, a_sdata_i, b_sdata_i;
  logic [1:0]  a_size_i, b_size_i;
  logic [63:0] a_sys_i, b_sys_i;
  logic        a_we_i, b_we_i;
  logic [4:0]  a_idx_i, b_idx_i;
  logic [31:0] a_wval_i, b_wval_i;
  logic        rollback_o;
  logic [2:0]  cause_o;

  int n_checks = 0;
  int n_errors = 0;

  // bench model state
  logic [15:0] m_sa = SEED, m_sb = SEED;
  int          m_cnt = 0;
  logic        m_roll = 1'b0;
  logic [2:0]  m_cause = 3'd0;

  always #4 clk = ~clk;

  dmr_retire_checker dut_i (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .cfg_period_i(cfg_period_i),
    .a_valid_i(a_valid_i), .a_class_i(a_class_i), .a_taken_i(a_taken_i),
    .a_npc_i(a_npc_i), .a_addr_i(a_addr_i), .a_size_i(a_size_i),
    .a_sdata_i(a_sdata_i), .a_sys_i(a_sys_i), .a_we_i(a_we_i),
    .a_idx_i(a_idx_i), .a_wval_i(a_wval_i),
    .b_valid_i(b_valid_i), .b_class_i(b_class_i), .b_taken_i(b_taken_i),
    .b_npc_i(b_npc_i), .b_addr_i(b_addr_i), .b_size_i(b_size_i),
    .b_sdata_i(b_sdata_i), .b_sys_i(b_sys_i), .b_we_i(b_we_i),
    .b_idx_i(b_idx_i), .b_wval_i(b_wval_i),
    .rollback_o(rollback_o), .cause_o(cause_o)
  );

  function automatic logic [15:0] fold(input logic [15:0] s, input logic [4:0] idx,
                                       input logic [31:0] val);
    logic [20:0] p;
    p = {16'd0, idx} * 21'h09E37;
    return {s[14:0], s[15]} ^ val[15:0] ^ p[15:0];
  endfunction

  task automatic report(input logic [2:0] exp_roll_c, input string tag);
    n_checks++;
    if (rollback_o !== m_roll || cause_o !== m_cause) begin
      n_errors++;
      $display("FAIL %s: rollback=%0b cause=%0d expected rollback=%0b cause=%0d",
               tag, rollback_o, cause_o, m_roll, m_cause);
    end
  endtask

  // fe: field violation code expected this cycle (already priority-resolved)
  task automatic step(input logic [2:0] fe, input string tag);
    logic [15:0] na, nb;
    logic        ret, last, serr;
    logic [2:0]  ne;
    int          per;
    na   = (a_valid_i && a_we_i) ? fold(m_sa, a_idx_i, a_wval_i) : m_sa;
    nb   = (b_valid_i && b_we_i) ? fold(m_sb, b_idx_i, b_wval_i) : m_sb;
    ret  = a_valid_i && b_valid_i;
    per  = (cfg_period_i == 8'd0) ? 1 : int'(cfg_period_i);
    last = ret && (m_cnt >= per - 1);
    serr = last && (na != nb);
    if (last) begin
      m_sa = SEED; m_sb = SEED; m_cnt = 0;
    end else begin
      m_sa = na; m_sb = nb;
      if (ret) m_cnt++;
    end
    ne = (fe != 3'd0) ? fe : (serr ? 3'd6 : 3'd0);
    if (ne != 3'd0 && (!m_roll || ack_i)) begin
      m_roll = 1'b1; m_cause = ne;
    end else if (ack_i) begin
      m_roll = 1'b0; m_cause = 3'd0;
    end
    @(posedge clk);
    #1;
    report(ne, tag);
  endtask

  task automatic idle();
    a_valid_i = 0; b_valid_i = 0; a_we_i = 0; b_we_i = 0;
  endtask

  task automatic same(input logic [2:0] cls, input logic [31:0] npc,
                      input logic [31:0] addr, input logic [1:0] sz,
                      input logic [31:0] sd);
    a_valid_i = 1; b_valid_i = 1;
    a_class_i = cls; b_class_i = cls;
    a_taken_i = 0; b_taken_i = 0;
    a_npc_i = npc; b_npc_i = npc;
    a_addr_i = addr; b_addr_i = addr;
    a_size_i = sz; b_size_i = sz;
    a_sdata_i = sd; b_sdata_i = sd;
    a_sys_i = 64'h0000_1111_2222_3333; b_sys_i = a_sys_i;
    a_we_i = 0; b_we_i = 0;
    a_idx_i = 0; b_idx_i = 0; a_wval_i = 0; b_wval_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 0; ack_i = 1; cfg_period_i = 8'd4;
    same(3'd0, 32'h100, 32'h0, 2'd0, 32'h0);
    idle();
    repeat (3) @(posedge clk);
    #1;
    report(3'd0, "R1 in reset");
    rst_n = 1;
    repeat (4) step(3'd0, "R1 after release");

    // R8 clean stream with equal writes
    for (int i = 0; i < 10; i++) begin
      same(3'd0, 32'h200 + i, 32'h0, 2'd0, 32'h0);
      a_we_i = 1; b_we_i = 1; a_idx_i = 5'(i); b_idx_i = 5'(i);
      a_wval_i = 32'h1234 * i; b_wval_i = a_wval_i;
      step(3'd0, "R8 equal writes");
    end

    // R2 one-sided records
    same(3'd0, 32'h10, 0, 0, 0); b_valid_i = 0; step(3'd1, "R2 only A");
    same(3'd0, 32'h10, 0, 0, 0); a_valid_i = 0; step(3'd1, "R2 only B");
    idle(); step(3'd0, "R10 ack clears");

    // R3 control fields
    same(3'd0, 32'h40, 0, 0, 0); b_npc_i = 32'h44; step(3'd1, "R3 npc");
    same(3'd0, 32'h40, 0, 0, 0); b_class_i = 3'd2; step(3'd1, "R3 class");
    same(3'd1, 32'h40, 0, 0, 0); b_taken_i = 1; step(3'd1, "R3 branch taken");
    same(3'd0, 32'h40, 0, 0, 0); b_taken_i = 1; step(3'd0, "R3 taken ignored on ALU");
    same(3'd1, 32'h40, 0, 0, 0); a_taken_i = 1; b_taken_i = 1; step(3'd0, "R3 equal branch");

    // R4 store address
    same(3'd3, 32'h50, 32'h80, 2'd2, 32'hCAFE); b_addr_i = 32'h84;
    step(3'd3, "R4 store addr");

    // R5 store data byte sweep
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        same(3'd3, 32'h60, 32'h40, 2'(s), 32'hA5A5_5A5A);
        b_sdata_i = a_sdata_i ^ (32'h1 << (8 * k));
        step((k < (1 << s)) ? 3'd2 : 3'd0, "R5 store byte");
      end
    end

    // R6 alignment sweep for loads and stores
    for (int c = 2; c < 4; c++) begin
      for (int s = 0; s < 4; s++) begin
        for (int lo = 0; lo < 8; lo++) begin
          same(3'(c), 32'h70, 32'h300 + lo, 2'(s), 32'h77);
          step(((lo & ((1 << s) - 1)) != 0) ? 3'd4 : 3'd0, "R6 alignment");
        end
      end
    end

    // R7 syscall inputs
    same(3'd4, 32'h90, 0, 0, 0); b_sys_i[0] = ~b_sys_i[0]; step(3'd5, "R7 arg0");
    same(3'd4, 32'h90, 0, 0, 0); b_sys_i[40] = ~b_sys_i[40]; step(3'd5, "R7 arg1");
    same(3'd4, 32'h90, 0, 0, 0); step(3'd0, "R7 equal args");

    // R11 priority
    same(3'd3, 32'hA0, 32'h80, 2'd2, 32'h1); b_npc_i = 32'hA4; b_addr_i = 32'h88;
    step(3'd1, "R11 ctrl over store addr");
    same(3'd3, 32'hA0, 32'h80, 2'd2, 32'h1); b_addr_i = 32'h88; b_sdata_i = 32'h2;
    step(3'd3, "R11 store addr over value");
    same(3'd3, 32'hA0, 32'h81, 2'd2, 32'h1); b_sdata_i = 32'h2;
    step(3'd2, "R11 store value over alignment");

    // R10 sticky behaviour
    ack_i = 0;
    same(3'd0, 32'h10, 0, 0, 0); b_valid_i = 0; step(3'd1, "R10 raise ctrl");
    same(3'd3, 32'hB0, 32'h80, 2'd2, 32'h1); b_addr_i = 32'h90;
    step(3'd3, "R10 later violation ignored");
    idle(); step(3'd0, "R10 hold");
    ack_i = 1;
    same(3'd3, 32'hB0, 32'h80, 2'd2, 32'h1); b_addr_i = 32'h90;
    step(3'd3, "R10 violation in ack cycle");
    idle(); step(3'd0, "R10 cleared");

    // R8/R9 signature sweep: difference in index at varying slots
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 8; j++) begin
        same(3'd0, 32'hC0 + j, 0, 0, 0);
        a_we_i = 1; b_we_i = 1;
        a_idx_i = 5'(j + i); b_idx_i = a_idx_i;
        a_wval_i = 32'(i * 977 + j); b_wval_i = a_wval_i;
        if (j == (i % 4)) b_idx_i = 5'(i) ^ 5'd1;
        if (j == 5 && i[0]) b_wval_i = a_wval_i ^ 32'h100;
        step(3'd0, "R8 R9 signature");
      end
    end
    // one-sided writes do not advance period; write-less cycles do
    same(3'd0, 32'h0, 0, 0, 0); step(3'd0, "R9 no write retire");
    idle(); step(3'd0, "R9 idle cycle");

    // R9 period zero acts as one
    cfg_period_i = 8'd0;
    for (int j = 0; j < 4; j++) begin
      same(3'd0, 32'hD0, 0, 0, 0);
      a_we_i = 1; b_we_i = 1; a_idx_i = 5'(j); b_idx_i = 5'(j);
      a_wval_i = 32'(j); b_wval_i = (j == 1) ? 32'h5 : 32'(j);
      step(3'd0, "R9 period zero");
    end
    idle(); step(3'd0, "R12 final");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule